// File: doc/BRIEF.md
# Pipelined Triangular Solve Array

This block solves L·X = B for small square tiles held inside a grid of NR×NR processing elements. L is lower triangular and B is a right-hand-side tile. Processing element (r,c) contributes one element of each matrix and a P-stage signed fixed-point multiply-accumulate pipeline. When the solve ends, X has replaced B in place. Each diagonal element of L is replaced by its reciprocal, which comes from a shared multi-cycle restoring divider. Data is signed Q8.8: 16 bits, 8 of them fraction bits.

The block holds P independent tiles, one for each pipeline slot. For each pivot index i, the controller first forms the reciprocal of the pivot of every tile. It then issues the row-i scaling for tile 0, 1, …, P−1 on consecutive cycles. For scaling, the reciprocal is broadcast along row i. Next it issues the rank-1 update for the rows below i in the same interleaved way. For the update, row i of X is broadcast down the columns and column i of L is broadcast across the rows. Intermediate values live only in the pipeline stages, so the bubbles that one tile would leave in the pipeline are filled by the other tiles.

Software loads and unloads one element per cycle through a port that selects a matrix, a tile, a row and a column. A one-cycle start pulse launches the solve. A one-cycle done pulse ends it.

The controller has these states:
- IDLE: wait for start.
- RCP_GO: launch the divider.
- RCP_WAIT: wait for the reciprocal and write it to the diagonal.
- SCALE: issue and drain the row scaling.
- UPDATE: issue and drain the rank-1 update.
- FINISH: pulse done.

It has these transitions:
- IDLE→RCP_GO on start.
- RCP_GO→RCP_WAIT always.
- RCP_WAIT→RCP_GO when the reciprocal arrives and more tiles remain.
- RCP_WAIT→SCALE when the reciprocal of the last tile arrives.
- SCALE→UPDATE when the drain ends on a pivot that is not the last.
- SCALE→FINISH when the drain ends on the last pivot.
- UPDATE→RCP_GO when the drain ends; the pivot index then advances.
- FINISH→IDLE always.

Top module: `trsm_tile_solver`

## Requirements
- R1: After reset, busy, done and err are 0, and every stored element reads back as 0.
- R2: While busy is 0, a cycle with ld_we=1 stores ld_wdata at the element addressed by ld_tile, ld_row and ld_col. ld_sel_l=1 selects the L matrix and ld_sel_l=0 selects the B/X matrix. ld_rdata shows the addressed element combinationally.
- R3: While busy is 1, writes through the load port are ignored, and the solve result does not change.
- R4: A start pulse in IDLE raises busy on the next cycle. At completion, done is 1 for exactly one cycle, and busy is 0 in that cycle.
- R5: For every tile, the B/X elements after done equal the exact solution of L·X = B to within 8 LSB. Each tile is solved independently of the other tiles.
- R6: After done, each diagonal element d of L holds its Q8.8 reciprocal: sign(d)·min(floor(65536/|d|), 32767). Elements below the diagonal are unchanged.
- R7: A zero diagonal element sets err, which stays set until the next start clears it. Its reciprocal is written as 0, so the matching row of X becomes 0.
- R8: Elements of L above the diagonal are never read or written by the solve.
- R9: A tile whose L is the identity leaves B exactly unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a solve (sampled in IDLE) |
| busy | output | 1 | Solve in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky zero-pivot flag |
| ld_we | input | 1 | Port write enable |
| ld_sel_l | input | 1 | 1 = L matrix, 0 = B/X matrix |
| ld_tile | input | $clog2(P) | Tile index |
| ld_row | input | $clog2(NR) | Row index |
| ld_col | input | $clog2(NR) | Column index |
| ld_wdata | input | W | Write data, Q8.8 |
| ld_rdata | output | W | Read data of the addressed element |

## Verification
The bench builds the block with its default parameters: a 4×4 grid and 4-stage pipelines, so four tiles are interleaved at once. Each scale and update phase therefore fills every pipeline slot, and a wrong tile tag or a write-back in the wrong cycle corrupts a neighbouring tile and shows up against the real-valued reference. The diagonals are powers of two of both signs, including 0.5, so the divider, the signed products and the 8-LSB tolerance are exercised together. The bench also covers the identity tile, the zero pivot in one tile and a write attempted while busy.

// File: rtl/trsm_pkg.sv
package trsm_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_RCP_GO,
        S_RCP_WAIT,
        S_SCALE,
        S_UPDATE,
        S_FINISH
    } solve_state_e;
endpackage

// File: rtl/trsm_recip.sv
module trsm_recip #(
    parameter int W    = 16,
    parameter int FRAC = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] x,
    output logic         rdy,
    output logic [W-1:0] q,
    output logic         is_zero
);
    localparam int DW = 2 * FRAC + 1;
    localparam int CW = $clog2(DW + 1);
    localparam logic [DW-1:0] ONE  = DW'(1) << (2 * FRAC);
    localparam logic [DW-1:0] MAXQ = DW'((1 << (W - 1)) - 1);

    logic          run, neg;
    logic [CW-1:0] cnt;
    logic [W:0]    rem, trial, rem_n;
    logic [DW-1:0] dvd, quo, quo_n, sat;
    logic [W-1:0]  mag;
    logic          fits;

    always_comb begin
        trial = {rem[W-1:0], dvd[DW-1]};
        fits  = trial >= {1'b0, mag};
        rem_n = fits ? trial - {1'b0, mag} : trial;
        quo_n = {quo[DW-2:0], fits};
        sat   = (quo_n > MAXQ) ? MAXQ : quo_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run <= 1'b0; neg <= 1'b0; cnt <= '0; rem <= '0;
            dvd <= '0; quo <= '0; mag <= '0;
            rdy <= 1'b0; q <= '0; is_zero <= 1'b0;
        end else begin
            rdy <= 1'b0;
            if (go) begin
                if (x == '0) begin
                    rdy     <= 1'b1;
                    q       <= '0;
                    is_zero <= 1'b1;
                    run     <= 1'b0;
                end else begin
                    run     <= 1'b1;
                    is_zero <= 1'b0;
                    neg     <= x[W-1];
                    mag     <= x[W-1] ? -x : x;
                    dvd     <= ONE;
                    rem     <= '0;
                    quo     <= '0;
                    cnt     <= CW'(DW);
                end
            end else if (run) begin
                rem <= rem_n;
                quo <= quo_n;
                dvd <= dvd << 1;
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    run <= 1'b0;
                    rdy <= 1'b1;
                    q   <= neg ? -sat[W-1:0] : sat[W-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/trsm_pe.sv
module trsm_pe #(
    parameter int W      = 16,
    parameter int FRAC   = 8,
    parameter int STAGES = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mul_mode,
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    input  logic signed [W-1:0] acc,
    output logic signed [W-1:0] res
);
    logic signed [2*W-1:0] prod;
    logic signed [W-1:0]   scaled, first;
    logic signed [W-1:0]   stg [STAGES];

    always_comb begin
        prod   = a * b;
        scaled = prod[FRAC+W-1:FRAC];
        first  = mul_mode ? scaled : acc - scaled;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= '0;
        end else begin
            stg[0] <= first;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign res = stg[STAGES-1];
endmodule

// File: rtl/trsm_tile_solver.sv
module trsm_tile_solver
    import trsm_pkg::*;
#(
    parameter int NR   = 4,
    parameter int P    = 4,
    parameter int W    = 16,
    parameter int FRAC = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    output logic                   busy,
    output logic                   done,
    output logic                   err,
    input  logic                   ld_we,
    input  logic                   ld_sel_l,
    input  logic [$clog2(P)-1:0]   ld_tile,
    input  logic [$clog2(NR)-1:0]  ld_row,
    input  logic [$clog2(NR)-1:0]  ld_col,
    input  logic [W-1:0]           ld_wdata,
    output logic [W-1:0]           ld_rdata
);
    localparam int T  = P;
    localparam int TW = $clog2(T);
    localparam int RW = $clog2(NR);
    localparam int PW = $clog2(T + P) + 1;
    localparam logic [PW-1:0] ISSUE_N = PW'(T);
    localparam logic [PW-1:0] LAST    = PW'(T + P - 1);

    solve_state_e state, state_n;
    logic [RW-1:0] it;
    logic [TW-1:0] rt, iss_tile;
    logic [PW-1:0] ph_cnt;
    logic          err_q, issuing, scale_ph;
    logic          tag_v [P];
    logic [TW-1:0] tag_t [P];
    logic signed [W-1:0] b_mem [T][NR][NR];
    logic signed [W-1:0] l_mem [T][NR][NR];
    logic signed [W-1:0] pe_res [NR][NR];
    logic          rcp_rdy, rcp_zero;
    logic [W-1:0]  rcp_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE:     if (start) state_n = S_RCP_GO;
            S_RCP_GO:   state_n = S_RCP_WAIT;
            S_RCP_WAIT: if (rcp_rdy) state_n = (rt == TW'(T - 1)) ? S_SCALE : S_RCP_GO;
            S_SCALE:    if (ph_cnt == LAST) state_n = (it == RW'(NR - 1)) ? S_FINISH : S_UPDATE;
            S_UPDATE:   if (ph_cnt == LAST) state_n = S_RCP_GO;
            S_FINISH:   state_n = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy     = !(state == S_IDLE || state == S_FINISH);
        done     = (state == S_FINISH);
        scale_ph = (state == S_SCALE);
        issuing  = (state == S_SCALE || state == S_UPDATE) && (ph_cnt < ISSUE_N);
        iss_tile = ph_cnt[TW-1:0];
    end
    assign err = err_q;
    assign ld_rdata = ld_sel_l ? l_mem[ld_tile][ld_row][ld_col]
                               : b_mem[ld_tile][ld_row][ld_col];

    // sequencing counters and tag line
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            it <= '0; rt <= '0; ph_cnt <= '0; err_q <= 1'b0;
            for (int k = 0; k < P; k++) begin tag_v[k] <= 1'b0; tag_t[k] <= '0; end
        end else begin
            tag_v[0] <= issuing;
            tag_t[0] <= iss_tile;
            for (int k = 1; k < P; k++) begin
                tag_v[k] <= tag_v[k-1];
                tag_t[k] <= tag_t[k-1];
            end
            if (state == S_IDLE && start) begin
                it <= '0; rt <= '0; ph_cnt <= '0; err_q <= 1'b0;
            end else if (state == S_RCP_WAIT && rcp_rdy) begin
                err_q  <= err_q | rcp_zero;
                rt     <= (rt == TW'(T - 1)) ? '0 : rt + 1'b1;
                ph_cnt <= '0;
            end else if (state == S_SCALE || state == S_UPDATE) begin
                ph_cnt <= (ph_cnt == LAST) ? '0 : ph_cnt + 1'b1;
                if (state == S_UPDATE && ph_cnt == LAST) it <= it + 1'b1;
            end
        end
    end

    // element storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int t = 0; t < T; t++)
                for (int r = 0; r < NR; r++)
                    for (int c = 0; c < NR; c++) begin
                        b_mem[t][r][c] <= '0;
                        l_mem[t][r][c] <= '0;
                    end
        end else begin
            if (ld_we && !busy) begin
                if (ld_sel_l) l_mem[ld_tile][ld_row][ld_col] <= ld_wdata;
                else          b_mem[ld_tile][ld_row][ld_col] <= ld_wdata;
            end
            if (state == S_RCP_WAIT && rcp_rdy) l_mem[rt][it][it] <= rcp_q;
            if (tag_v[P-1]) begin
                for (int r = 0; r < NR; r++)
                    for (int c = 0; c < NR; c++)
                        if (scale_ph ? (RW'(r) == it) : (RW'(r) > it))
                            b_mem[tag_t[P-1]][r][c] <= pe_res[r][c];
            end
        end
    end

    trsm_recip #(.W(W), .FRAC(FRAC)) u_recip (
        .clk(clk), .rst_n(rst_n), .go(state == S_RCP_GO),
        .x(l_mem[rt][it][it]), .rdy(rcp_rdy), .q(rcp_q), .is_zero(rcp_zero)
    );

    for (genvar gr = 0; gr < NR; gr++) begin : g_row
        for (genvar gc = 0; gc < NR; gc++) begin : g_col
            trsm_pe #(.W(W), .FRAC(FRAC), .STAGES(P)) u_pe (
                .clk(clk), .rst_n(rst_n), .mul_mode(scale_ph),
                .a  (scale_ph ? b_mem[iss_tile][it][gc] : l_mem[iss_tile][gr][it]),
                .b  (scale_ph ? l_mem[iss_tile][it][it] : b_mem[iss_tile][it][gc]),
                .acc(b_mem[iss_tile][gr][gc]),
                .res(pe_res[gr][gc])
            );
        end
    end

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
    // R4
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
    // R4
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state == S_IDLE) |=> busy);
    // R7
    err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> $past(state == S_RCP_WAIT));
    // R5
    wb_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tag_v[P-1] |-> (state == S_SCALE || state == S_UPDATE));
endmodule

// File: tb/trsm_tile_solver_test.sv
`timescale 1ns/1ps
module trsm_tile_solver_test;
    localparam int NR  = 4;
    localparam int P   = 4;
    localparam int W   = 16;
    localparam int T   = P;
    localparam int TOL = 8;
    localparam int SEEDS [5] = '{0, 1, 2, 3, 6};
    localparam int DIAG  [8] = '{256, 512, -512, 1024, 128, 256, -256, 512};

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic busy, done, err;
    logic ld_we = 1'b0, ld_sel_l = 1'b0;
    logic [1:0] ld_tile = '0, ld_row = '0, ld_col = '0;
    logic [W-1:0] ld_wdata = '0, ld_rdata;

    int checks = 0, fails = 0;
    bit finished = 0;
    int Lv [T][NR][NR];
    int Bv [T][NR][NR];
    real xr [NR][NR];

    always #5 clk = ~clk;

    trsm_tile_solver #(.NR(NR), .P(P), .W(W), .FRAC(8)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .err(err),
        .ld_we(ld_we), .ld_sel_l(ld_sel_l), .ld_tile(ld_tile), .ld_row(ld_row),
        .ld_col(ld_col), .ld_wdata(ld_wdata), .ld_rdata(ld_rdata)
    );

    task automatic chk(string req, int got, int exp, int tol);
        int d = got - exp;
        checks++;
        if (d < 0) d = -d;
        if (d > tol) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic wr(bit sel, int t, int r, int c, int v);
        @(negedge clk);
        ld_we = 1'b1; ld_sel_l = sel; ld_tile = 2'(t); ld_row = 2'(r); ld_col = 2'(c);
        ld_wdata = 16'(v);
        @(posedge clk); #1;
        ld_we = 1'b0;
    endtask

    task automatic rd(bit sel, int t, int r, int c, output int v);
        @(negedge clk);
        ld_sel_l = sel; ld_tile = 2'(t); ld_row = 2'(r); ld_col = 2'(c);
        #1;
        v = int'($signed(ld_rdata));
    endtask

    function automatic int rcp_exp(int d);
        int m, q;
        if (d == 0) return 0;
        m = (d < 0) ? -d : d;
        q = 65536 / m;
        if (q > 32767) q = 32767;
        return (d < 0) ? -q : q;
    endfunction

    // mode 0: mixed tile, mode 1: identity L, mode 2: zero pivot in tile 1 row 2
    task automatic build(int k, int mode);
        for (int t = 0; t < T; t++)
            for (int r = 0; r < NR; r++)
                for (int c = 0; c < NR; c++) begin
                    if (r == c) Lv[t][r][c] = (mode == 1) ? 256 : DIAG[(r + 2*t + k) % 8];
                    else if (r > c) Lv[t][r][c] = (mode == 1) ? 0 : (((r*3 + c*5 + t + k) % 5) - 2) * 64;
                    else Lv[t][r][c] = 23130;
                    if (mode == 2 && t == 1 && r == 2 && c == 2) Lv[t][r][c] = 0;
                    Bv[t][r][c] = (((r*7 + c*3 + t*5 + k) % 9) - 4) * 96;
                end
    endtask

    task automatic load_all();
        for (int t = 0; t < T; t++)
            for (int r = 0; r < NR; r++)
                for (int c = 0; c < NR; c++) begin
                    wr(1'b1, t, r, c, Lv[t][r][c]);
                    wr(1'b0, t, r, c, Bv[t][r][c]);
                end
    endtask

    task automatic ref_tile(int t);
        for (int r = 0; r < NR; r++)
            for (int c = 0; c < NR; c++) xr[r][c] = Bv[t][r][c] / 256.0;
        for (int i = 0; i < NR; i++) begin
            real rc = (Lv[t][i][i] == 0) ? 0.0 : 256.0 / Lv[t][i][i];
            for (int c = 0; c < NR; c++) xr[i][c] = xr[i][c] * rc;
            for (int r = i + 1; r < NR; r++)
                for (int c = 0; c < NR; c++)
                    xr[r][c] = xr[r][c] - (Lv[t][r][i] / 256.0) * xr[i][c];
        end
    endtask

    task automatic run_solve(bit poke);
        int n = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R4 busy after start", int'(busy), 1, 0);
        if (poke) begin
            wr(1'b0, 0, 0, 0, 16'h7777);
            wr(1'b1, 0, 1, 0, 16'h4444);
        end
        while (!done && n < 20000) begin @(negedge clk); n++; end
        chk("R4 done seen", int'(done), 1, 0);
        chk("R4 busy low at done", int'(busy), 0, 0);
        @(negedge clk);
        chk("R4 done one cycle", int'(done), 0, 0);
    endtask

    task automatic check_results(int mode);
        int v, e;
        for (int t = 0; t < T; t++) begin
            ref_tile(t);
            for (int r = 0; r < NR; r++)
                for (int c = 0; c < NR; c++) begin
                    real s = xr[r][c] * 256.0;
                    e = $rtoi(s >= 0.0 ? s + 0.5 : s - 0.5);
                    rd(1'b0, t, r, c, v);
                    if (mode == 1) chk("R9 identity X", v, Bv[t][r][c], 0);
                    else if (mode == 2 && Lv[t][r][r] == 0) chk("R7 zero row", v, 0, 0);
                    else chk("R5 X element", v, e, TOL);
                    rd(1'b1, t, r, c, v);
                    if (r == c) chk((Lv[t][r][c] == 0) ? "R7 forced zero recip" : "R6 recip",
                                    v, rcp_exp(Lv[t][r][c]), 0);
                    else if (r > c) chk("R6 lower L kept", v, Lv[t][r][c], 0);
                    else chk("R8 upper L untouched", v, Lv[t][r][c], 0);
                end
        end
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy", int'(busy), 0, 0);
        chk("R1 done", int'(done), 0, 0);
        chk("R1 err", int'(err), 0, 0);
        rd(1'b0, 3, 3, 3, v); chk("R1 B reset", v, 0, 0);
        rd(1'b1, 2, 1, 0, v); chk("R1 L reset", v, 0, 0);

        // table-driven mixed cases
        foreach (SEEDS[s]) begin
            build(SEEDS[s], 0);
            load_all();
            if (s == 0) begin
                rd(1'b0, 2, 3, 1, v); chk("R2 B readback", v, Bv[2][3][1], 0);
                rd(1'b1, 3, 2, 0, v); chk("R2 L readback", v, Lv[3][2][0], 0);
            end
            run_solve(s == 2);
            check_results(0);
            if (s == 2) begin
                ref_tile(0);
                rd(1'b0, 0, 0, 0, v);
                chk("R3 B write while busy", v, $rtoi(xr[0][0] * 256.0), TOL);
                rd(1'b1, 0, 1, 0, v);
                chk("R3 L write while busy", v, Lv[0][1][0], 0);
            end
            chk("R7 no err on good pivots", int'(err), 0, 0);
        end

        // identity tiles
        build(4, 1);
        load_all();
        run_solve(1'b0);
        check_results(1);

        // zero pivot
        build(1, 2);
        load_all();
        run_solve(1'b0);
        check_results(2);
        chk("R7 err set", int'(err), 1, 0);
        repeat (3) @(negedge clk);
        chk("R7 err sticky", int'(err), 1, 0);

        // err cleared by next start
        build(2, 0);
        load_all();
        run_solve(1'b0);
        chk("R7 err cleared", int'(err), 0, 0);
        check_results(0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule